// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a bank of 32-bit control and status words behind a simple word-access request port covering a 4 KiB window. A requester presents an address, a direction and write data for one cycle. The block answers in the following cycle with read data and a one-cycle illegal-access flag. There are no wait states. The request side has no back-pressure: a new request may be issued on every cycle and each is accepted. The response also cannot be stalled, so the requester must take it in the cycle it is valid.

An unlock word guards the lower part of the map. While it holds 0, writes into the guarded range are dropped. Strap words and a revision word are loaded from pins during reset, and the revision picks one of two device families. On the newer family, one strap word only accepts bit-set writes, and writing the revision word's address clears strap bits. Some words are read-only, one is write-only, and one returns a fresh pseudo-random word on every read. A divider value for the peripheral bus follows a field of the clock-select word.

Top module: `scu_regfile`

## Requirements
- R1: Every cycle with req_valid high is accepted. Exactly one cycle later, rsp_valid is high with rsp_rdata and rsp_err. rsp_valid is low after a cycle without a request, and write responses carry rsp_rdata = 0.
- R2: A request is illegal if the address is not 4-byte aligned or if its word index (addr/4) is at or above NUM_REGS (default 106, so offsets 0x1A8 and above). For an illegal request, a read returns 0, a write changes nothing, and rsp_err is 1.
- R3: A write to offset 0x00 stores 1 if the data equals UNLOCK_KEY (default 0xC0DE5A17) and 0 otherwise. A read of 0x00 returns that 0/1 value.
- R4: While the unlock value is 0, writes to offsets 0x04 through 0x100 are dropped with rsp_err = 1. Offsets 0x104 and above stay writable at all times.
- R5: During reset, the following values are loaded:
  - 0x00 takes boot_unlock.
  - 0x7C takes rev_in, 0x70 takes strap1_in and 0xD0 takes strap2_in.
  - 0x04 = 0xFFCFFEDC, 0x08 = 0xF3F40000, 0x74 = 0x0000000E and 0x104 = 0x80000000.
  - 0x24 = 0x00000291 on the older family and 0x93000400 on the newer one.
  - Every other word is 0.
- R6: The newer family is selected when rev bits [31:24] equal 0x04. On that family, a write to 0x70 ORs the data into the stored strap word.
- R7: On the newer family, a write to 0x7C clears the strap bits at 0x70 wherever the data has a 1. The word at 0x7C itself never changes, and rsp_err stays 0.
- R8: On the older family, a write to 0x7C is dropped with rsp_err = 1, and a write to 0x70 overwrites the word.
- R9: Writes to the read-only words are dropped with rsp_err = 1. These words are 0x14, the eight words 0x50 to 0x6C, 0x78, 0xE0 and 0xE4.
- R10: Each read of 0x78 first advances a 32-bit LFSR and then returns the new state. The LFSR step is s' = {s[30:0], s[31]^s[21]^s[1]^s[0]}, and the state resets to LFSR_SEED (default 1). The content of 0x74 has no effect on this.
- R11: A read of the write-only word 0xC0 returns its stored value with rsp_err = 1.
- R12: pbus_div equals (clock-select bits [25:23] + 1) × F, where F is 2 for the older family and 4 for the newer one. It follows the reset value of 0x08 and changes one cycle after an accepted write to 0x08.
- R13: Legal accesses not named above give rsp_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| boot_unlock | input | 1 | Initial unlock state |
| rev_in | input | 32 | Revision word loaded at reset |
| strap1_in | input | 32 | First strap word loaded at reset |
| strap2_in | input | 32 | Second strap word loaded at reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Illegal-access pulse |
| pbus_div | output | 6 | Peripheral-bus divider value |

## Verification
The bench uses the default parameters: NUM_REGS = 106, a 12-bit address, the default key and seed. This puts both the top of the implemented array (0x1A4 legal, 0x1A8 illegal) and the end of the 4 KiB window within reach. It resets the block twice, once with an older-family revision and boot locked, and once with a newer-family revision and boot unlocked. Both strap semantics, both divider factors and both initial lock states are therefore exercised against a behavioural model with back-to-back requests.

// File: rtl/scu_pkg.sv
package scu_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned IDX_KEY     = 0;
  localparam int unsigned IDX_RSTCTL  = 1;
  localparam int unsigned IDX_CLKSEL  = 2;
  localparam int unsigned IDX_FCNT    = 5;
  localparam int unsigned IDX_PLLH    = 9;
  localparam int unsigned IDX_SCR_LO  = 20;
  localparam int unsigned IDX_SCR_HI  = 27;
  localparam int unsigned IDX_STRAP1  = 28;
  localparam int unsigned IDX_RNGCTL  = 29;
  localparam int unsigned IDX_RNG     = 30;
  localparam int unsigned IDX_REV     = 31;
  localparam int unsigned IDX_WONLY   = 48;
  localparam int unsigned IDX_STRAP2  = 52;
  localparam int unsigned IDX_CNT0    = 56;
  localparam int unsigned IDX_CNT1    = 57;
  localparam int unsigned IDX_OPEN    = 65;  // first word outside the guarded range
  localparam logic [7:0]  NEWER_TAG   = 8'h04;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_KEY,
    WK_PLAIN,
    WK_OR,
    WK_CLR
  } wr_kind_t;

  function automatic logic fam_newer(input logic [WORD_W-1:0] rev);
    return rev[31:24] == NEWER_TAG;
  endfunction

  function automatic logic [WORD_W-1:0] reset_word(input int unsigned idx, input logic newer);
    logic [WORD_W-1:0] v;
    case (idx)
      IDX_RSTCTL: v = 32'hFFCF_FEDC;
      IDX_CLKSEL: v = 32'hF3F4_0000;
      IDX_PLLH:   v = newer ? 32'h9300_0400 : 32'h0000_0291;
      IDX_RNGCTL: v = 32'h0000_000E;
      IDX_OPEN:   v = 32'h8000_0000;
      default:    v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/scu_decode.sv
module scu_decode
  import scu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 106
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-3:0] idx,
  output logic              legal,
  output logic              f_key,
  output logic              f_guarded,
  output logic              f_ro,
  output logic              f_wo,
  output logic              f_clksel,
  output logic              f_strap1,
  output logic              f_rev,
  output logic              f_rng
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  always_comb begin
    idx       = addr[ADDR_W-1:2];
    legal     = (addr[1:0] == 2'b00) && (int'(idx) < int'(NUM_REGS));
    f_key     = (idx == IDX_W'(IDX_KEY));
    f_guarded = !f_key && (int'(idx) < int'(IDX_OPEN));
    f_ro      = (idx == IDX_W'(IDX_FCNT)) || (idx == IDX_W'(IDX_RNG)) ||
                (idx == IDX_W'(IDX_CNT0)) || (idx == IDX_W'(IDX_CNT1)) ||
                ((int'(idx) >= int'(IDX_SCR_LO)) && (int'(idx) <= int'(IDX_SCR_HI)));
    f_wo      = (idx == IDX_W'(IDX_WONLY));
    f_clksel  = (idx == IDX_W'(IDX_CLKSEL));
    f_strap1  = (idx == IDX_W'(IDX_STRAP1));
    f_rev     = (idx == IDX_W'(IDX_REV));
    f_rng     = (idx == IDX_W'(IDX_RNG));
  end
endmodule

// File: rtl/scu_lfsr.sv
module scu_lfsr #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] SEED = W'(1),
  parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] next
);
  logic [W-1:0] state;

  always_comb next = {state[W-2:0], ^(state & TAPS)};

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= next;
  end

  // R10: each step yields a new value
  a_r10_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state != $past(state));
endmodule

// File: rtl/scu_pdiv.sv
module scu_pdiv #(
  parameter int unsigned FIELD_LSB = 23,
  parameter int unsigned FIELD_W   = 3,
  parameter int unsigned DIV_W     = FIELD_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             newer,
  input  logic [31:0]      rst_value,
  input  logic             load,
  input  logic [31:0]      load_value,
  output logic [DIV_W-1:0] div
);
  function automatic logic [DIV_W-1:0] calc(input logic [31:0] v, input logic nf);
    logic [DIV_W-1:0] f;
    f = DIV_W'(v[FIELD_LSB +: FIELD_W]) + DIV_W'(1);
    return nf ? (f << 2) : (f << 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    div <= calc(rst_value, newer);
    else if (load) div <= calc(load_value, newer);
  end

  // R12: divider only moves on an accepted clock-select write
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(div));
endmodule

// File: rtl/scu_regfile.sv
module scu_regfile
  import scu_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_REGS   = 106,
  parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5A17,
  parameter logic [31:0] LFSR_SEED  = 32'h0000_0001,
  parameter int unsigned DIV_LSB    = 23,
  parameter int unsigned DIV_FW     = 3,
  localparam int unsigned DIV_W     = DIV_FW + 3,
  localparam int unsigned IDX_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_unlock,
  input  logic [31:0]       rev_in,
  input  logic [31:0]       strap1_in,
  input  logic [31:0]       strap2_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [DIV_W-1:0]  pbus_div
);
  logic [31:0] regs [NUM_REGS];

  logic [IDX_W-1:0] idx;
  logic legal, f_key, f_guarded, f_ro, f_wo, f_clksel, f_strap1, f_rev, f_rng;
  logic        newer, unlocked, rng_step, err_n;
  logic [31:0] rng_next, rdata_n, sel_word;
  wr_kind_t    wk;

  scu_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) i_dec (
    .addr(req_addr), .idx(idx), .legal(legal), .f_key(f_key),
    .f_guarded(f_guarded), .f_ro(f_ro), .f_wo(f_wo), .f_clksel(f_clksel),
    .f_strap1(f_strap1), .f_rev(f_rev), .f_rng(f_rng)
  );

  assign newer    = rst_n ? fam_newer(regs[IDX_REV]) : fam_newer(rev_in);
  assign unlocked = regs[IDX_KEY][0];
  assign rng_step = req_valid && !req_write && legal && f_rng;
  assign sel_word = legal ? regs[idx] : '0;

  scu_lfsr #(.W(32), .SEED(LFSR_SEED)) i_rng (
    .clk(clk), .rst_n(rst_n), .step(rng_step), .next(rng_next)
  );

  // classify the request
  always_comb begin
    wk      = WK_NONE;
    err_n   = 1'b0;
    rdata_n = '0;
    if (req_valid) begin
      if (!legal) begin
        err_n = 1'b1;
      end else if (!req_write) begin
        rdata_n = f_rng ? rng_next : sel_word;
        err_n   = f_wo;
      end else if (f_key) begin
        wk = WK_KEY;
      end else if (f_guarded && !unlocked) begin
        err_n = 1'b1;
      end else if (f_ro) begin
        err_n = 1'b1;
      end else if (f_rev) begin
        if (newer) wk = WK_CLR;
        else       err_n = 1'b1;
      end else if (f_strap1 && newer) begin
        wk = WK_OR;
      end else begin
        wk = WK_PLAIN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_REGS); i++) regs[i] <= reset_word(i, fam_newer(rev_in));
      regs[IDX_KEY]    <= {31'b0, boot_unlock};
      regs[IDX_REV]    <= rev_in;
      regs[IDX_STRAP1] <= strap1_in;
      regs[IDX_STRAP2] <= strap2_in;
    end else begin
      case (wk)
        WK_KEY:   regs[IDX_KEY]    <= {31'b0, req_wdata == UNLOCK_KEY};
        WK_OR:    regs[IDX_STRAP1] <= regs[IDX_STRAP1] | req_wdata;
        WK_CLR:   regs[IDX_STRAP1] <= regs[IDX_STRAP1] & ~req_wdata;
        WK_PLAIN: regs[idx]        <= req_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rdata_n;
      rsp_err   <= err_n;
    end
  end

  scu_pdiv #(.FIELD_LSB(DIV_LSB), .FIELD_W(DIV_FW)) i_div (
    .clk(clk), .rst_n(rst_n), .newer(newer),
    .rst_value(reset_word(IDX_CLKSEL, newer)),
    .load((wk == WK_PLAIN) && f_clksel), .load_value(req_wdata),
    .div(pbus_div)
  );

  // R1: response exactly one cycle after each request
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_err);
  // R2: illegal address reads as zero with the flag
  a_r2_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !legal |=> rsp_err && rsp_rdata == 32'h0);
  // R3: the magic value unlocks
  a_r3_key_magic: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && legal && f_key && req_wdata == UNLOCK_KEY |=> unlocked);
  // R4: guarded write while locked is flagged
  a_r4_locked_err: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && legal && f_guarded && !unlocked |=> rsp_err);
  // R7: revision word never changes after reset
  a_r7_rev_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(regs[IDX_REV]));
endmodule

// File: tb/test_scu_regfile.sv
`timescale 1ns/1ps
module test_scu_regfile;
  localparam logic [31:0] KEY = 32'hC0DE_5A17;

  logic        clk = 0, rst_n = 0, boot_unlock = 0;
  logic [31:0] rev_in = 0, strap1_in = 0, strap2_in = 0;
  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [5:0]  pbus_div;

  int checks = 0, errors = 0;

  // behavioural model
  logic [31:0] m [int];
  logic [31:0] m_lfsr;
  logic        m_new;
  int          m_div;

  always #4 clk = ~clk;

  scu_regfile i_scu_regfile (
    .clk(clk), .rst_n(rst_n), .boot_unlock(boot_unlock), .rev_in(rev_in),
    .strap1_in(strap1_in), .strap2_in(strap2_in), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .pbus_div(pbus_div)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] rd(input int a);
    return m.exists(a) ? m[a] : 32'h0;
  endfunction

  function automatic int divof(input logic [31:0] v);
    return (int'(v[25:23]) + 1) * (m_new ? 4 : 2);
  endfunction

  task automatic note(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic do_reset(input logic [31:0] rev, input logic [31:0] s1,
                          input logic [31:0] s2, input logic unl);
    @(negedge clk);
    rst_n = 0; rev_in = rev; strap1_in = s1; strap2_in = s2; boot_unlock = unl;
    req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m.delete();
    m_new = (rev[31:24] == 8'h04);
    m[32'h00] = {31'b0, unl};
    m[32'h04] = 32'hFFCF_FEDC;
    m[32'h08] = 32'hF3F4_0000;
    m[32'h24] = m_new ? 32'h9300_0400 : 32'h0000_0291;
    m[32'h74] = 32'h0000_000E;
    m[32'h104] = 32'h8000_0000;
    m[32'h70] = s1; m[32'h7C] = rev; m[32'hD0] = s2;
    m_lfsr = 32'h1;
    m_div = divof(32'hF3F4_0000);
    #1;
    note(rsp_valid == 0 && rsp_err == 0 && int'(pbus_div) == m_div, "R5",
         $sformatf("after reset valid=%0b err=%0b div=%0d exp 0/0/%0d",
                   rsp_valid, rsp_err, pbus_div, m_div));
  endtask

  task automatic xfer(input bit wr, input int a, input logic [31:0] d, input string tag);
    logic [31:0] er;
    logic        ee;
    int          ix;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a[11:0]; req_wdata = d;
    er = 0; ee = 0; ix = a / 4;
    if ((a % 4) != 0 || ix >= 106) ee = 1;
    else if (!wr) begin
      if (a == 32'h78) begin m_lfsr = step(m_lfsr); er = m_lfsr; end
      else er = rd(a);
      ee = (a == 32'hC0);
    end else if (a == 0) m[0] = {31'b0, d == KEY};
    else if (a < 32'h104 && rd(0) == 0) ee = 1;
    else if (a == 32'h14 || (a >= 32'h50 && a <= 32'h6C) || a == 32'h78 ||
             a == 32'hE0 || a == 32'hE4) ee = 1;
    else if (a == 32'h7C) begin
      if (m_new) m[32'h70] = rd(32'h70) & ~d; else ee = 1;
    end else if (a == 32'h70 && m_new) m[32'h70] = rd(32'h70) | d;
    else begin
      m[a] = d;
      if (a == 32'h08) m_div = divof(d);
    end
    @(posedge clk); #2;
    req_valid = 0;
    note(rsp_valid == 1 && rsp_rdata == er && rsp_err == ee && int'(pbus_div) == m_div, tag,
         $sformatf("%s 0x%03h: got v=%0b d=%08h e=%0b div=%0d exp v=1 d=%08h e=%0b div=%0d",
                   wr ? "wr" : "rd", a, rsp_valid, rsp_rdata, rsp_err, pbus_div,
                   er, ee, m_div));
  endtask

  task automatic idle(input string tag);
    @(negedge clk); req_valid = 0;
    @(posedge clk); #2;
    note(rsp_valid == 0 && rsp_err == 0, tag,
         $sformatf("idle got v=%0b e=%0b exp 0/0", rsp_valid, rsp_err));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // older family, booted locked
    do_reset(32'h0200_0003, 32'h0000_F0F0, 32'h1234_5678, 1'b0);
    xfer(0, 32'h00, 0, "R5");
    xfer(0, 32'h70, 0, "R5");
    xfer(0, 32'hD0, 0, "R5");
    xfer(0, 32'h7C, 0, "R5");
    xfer(0, 32'h04, 0, "R5");
    xfer(0, 32'h24, 0, "R5");
    xfer(0, 32'h104, 0, "R5");
    idle("R1");
    xfer(1, 32'h04, 32'h1111_2222, "R4");
    xfer(0, 32'h04, 0, "R4");
    xfer(1, 32'h100, 32'hAAAA_0001, "R4");
    xfer(1, 32'h104, 32'h5555_6666, "R4");
    xfer(0, 32'h104, 0, "R4");
    xfer(1, 32'h1A4, 32'h0BAD_F00D, "R4");
    xfer(0, 32'h1A4, 0, "R13");
    xfer(1, 32'h00, 32'h1234_0000, "R3");
    xfer(0, 32'h00, 0, "R3");
    xfer(1, 32'h00, KEY, "R3");
    xfer(0, 32'h00, 0, "R3");
    xfer(1, 32'h04, 32'h1111_2222, "R13");
    xfer(0, 32'h04, 0, "R13");
    xfer(1, 32'h08, 32'h0100_0000, "R12");
    xfer(0, 32'h08, 0, "R12");
    xfer(1, 32'h08, 32'h0380_0000, "R12");
    xfer(1, 32'h70, 32'h0000_000F, "R8");
    xfer(0, 32'h70, 0, "R8");
    xfer(1, 32'h7C, 32'hFFFF_FFFF, "R8");
    xfer(0, 32'h7C, 0, "R8");
    xfer(0, 32'h70, 0, "R8");
    xfer(1, 32'h14, 32'hDEAD_BEEF, "R9");
    xfer(0, 32'h14, 0, "R9");
    xfer(1, 32'h50, 32'hDEAD_BEEF, "R9");
    xfer(1, 32'h6C, 32'hDEAD_BEEF, "R9");
    xfer(0, 32'h6C, 0, "R9");
    xfer(1, 32'hE0, 32'h1, "R9");
    xfer(1, 32'hE4, 32'h1, "R9");
    xfer(0, 32'hE4, 0, "R9");
    xfer(1, 32'h78, 32'h1, "R9");
    xfer(0, 32'h78, 0, "R10");
    xfer(0, 32'h78, 0, "R10");
    xfer(1, 32'h74, 32'h0, "R10");
    xfer(0, 32'h78, 0, "R10");
    for (int k = 0; k < 40; k++) xfer(0, 32'h78, 0, "R10");
    xfer(1, 32'hC0, 32'h0000_ABCD, "R11");
    xfer(0, 32'hC0, 0, "R11");
    xfer(0, 32'h06, 0, "R2");
    xfer(1, 32'h09, 32'hFFFF_FFFF, "R2");
    xfer(0, 32'h08, 0, "R2");
    xfer(0, 32'h1A8, 0, "R2");
    xfer(1, 32'h1A8, 32'h7, "R2");
    xfer(0, 32'hFFC, 0, "R2");
    xfer(1, 32'h00, 32'h0, "R3");
    xfer(1, 32'h04, 32'h9999_0000, "R4");
    xfer(0, 32'h04, 0, "R4");
    idle("R1");

    // newer family, booted unlocked
    do_reset(32'h0400_0303, 32'h0000_00F0, 32'h0000_0011, 1'b1);
    xfer(0, 32'h00, 0, "R5");
    xfer(0, 32'h24, 0, "R5");
    xfer(0, 32'h04, 0, "R5");
    xfer(1, 32'h70, 32'h0000_0F00, "R6");
    xfer(0, 32'h70, 0, "R6");
    xfer(1, 32'h70, 32'h0000_0000, "R6");
    xfer(0, 32'h70, 0, "R6");
    xfer(1, 32'h7C, 32'h0000_0330, "R7");
    xfer(0, 32'h70, 0, "R7");
    xfer(0, 32'h7C, 0, "R7");
    xfer(1, 32'h08, 32'h0080_0000, "R12");
    xfer(0, 32'h78, 0, "R10");
    xfer(1, 32'h00, 32'h0, "R3");
    xfer(1, 32'h70, 32'hFFFF_FFFF, "R4");
    xfer(0, 32'h70, 0, "R4");
    idle("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule